// File: doc/BRIEF.md
# Timer Output-Compare Channel with Forced Match

This block is a single output-compare channel for a 16-bit timer. Each clock it compares the running counter value with a compare register. When the counter is enabled and the two values are equal, the channel raises a one-cycle match pulse for the interrupt logic. It also drives its waveform pin according to a 2-bit action select. When the timer runs in clear-on-compare mode, it asks the counter to restart.

Software can also issue a force strobe. The strobe applies the currently selected pin action at once, as if a match had happened. It raises no match pulse and no counter-restart request. The strobe only works while the timer is in a non-PWM mode. In PWM modes it is ignored, and waveform shaping is left to separate logic.

All three outputs are registered. Their effect appears in the cycle after the input condition is sampled.

Top module: `ocf_channel`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `wave_o`, `match_irq` and `clr_req` are all 0.
- R2: When `cnt_en` is 1 and `cnt_val` equals `cmp_val` at a clock edge, `match_irq` is 1 for exactly the following cycle.
- R3: When `cnt_en` is 0, equal counter and compare values produce no `match_irq`, no `clr_req` and no pin action.
- R4: On a match outside PWM mode, `wave_o` changes in the next cycle according to `out_mode`: 2'b00 holds, 2'b01 inverts, 2'b10 drives 0, 2'b11 drives 1.
- R5: `clr_req` is 1 in the cycle after a match only if `ctc_mode` was 1 and `pwm_mode` was 0 at that edge.
- R6: When `force_stb` is 1 and `pwm_mode` is 0, `wave_o` takes the `out_mode` action of that same edge in the next cycle, with no counter match needed.
- R7: A force strobe alone never sets `match_irq`.
- R8: A force strobe alone never sets `clr_req`, even when `ctc_mode` is 1.
- R9: When `pwm_mode` is 1, a force strobe leaves `wave_o` unchanged.
- R10: When a force strobe and a real match arrive on the same edge, the pin action is applied once (a toggle inverts exactly once), and `match_irq` is still set.
- R11: A match in PWM mode still sets `match_irq`, but `wave_o` is held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cnt_val | input | CW | Current timer count |
| cnt_en | input | 1 | Counter advancing this cycle; qualifies matches |
| cmp_val | input | CW | Compare register value |
| out_mode | input | 2 | Pin action select on match/force |
| pwm_mode | input | 1 | Timer in a PWM waveform mode |
| ctc_mode | input | 1 | Timer clears on this channel's compare |
| force_stb | input | 1 | One-cycle force-compare strobe |
| wave_o | output | 1 | Waveform pin level |
| match_irq | output | 1 | One-cycle compare-match interrupt pulse |
| clr_req | output | 1 | One-cycle counter-clear request |

## Verification
A wrong stored pin level shows up on `wave_o` in the very next cycle, and it stays wrong. No later action other than set or clear will fix it, so toggle sequences make the error obvious. A match pulse or clear request that comes from a force strobe, or a clear request that appears in PWM mode, shows as a stray one-cycle pulse on the following cycle. A doubled action when force and match coincide only shows for the toggle action. That case is therefore driven with `out_mode` set to toggle, and `wave_o` is checked after it.

// File: rtl/occ_pkg.sv
package occ_pkg;

    typedef enum logic [1:0] {
        OM_HOLD   = 2'b00,
        OM_TOGGLE = 2'b01,
        OM_CLEAR  = 2'b10,
        OM_SET    = 2'b11
    } om_e;

    function automatic logic om_apply(input om_e mode, input logic cur);
        logic nxt;
        case (mode)
            OM_TOGGLE: nxt = ~cur;
            OM_CLEAR:  nxt = 1'b0;
            OM_SET:    nxt = 1'b1;
            default:   nxt = cur;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/occ_cmp.sv
module occ_cmp #(
    parameter int CW = 16
) (
    input  logic [CW-1:0] cnt_val,
    input  logic [CW-1:0] cmp_val,
    input  logic          cnt_en,
    output logic          hit
);
    logic [CW-1:0] same;

    // per-bit equality, reduced below
    for (genvar i = 0; i < CW; i++) begin : g_bit
        assign same[i] = ~(cnt_val[i] ^ cmp_val[i]);
    end

    assign hit = cnt_en & (&same);

endmodule

// File: rtl/occ_wave.sv
module occ_wave
    import occ_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       fire,
    input  logic [1:0] mode,
    output logic       wave_o
);
    typedef struct packed {
        logic lvl;
    } wave_st_t;

    wave_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (fire) begin
            st_d.lvl = om_apply(om_e'(mode), st_q.lvl);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign wave_o = st_q.lvl;

    // R4: a toggle action inverts the pin exactly once
    p_toggle_r4: assert property (@(posedge clk) disable iff (rst)
        ($past(fire) && $past(mode) == 2'b01 && !$past(rst)) |-> (wave_o != $past(wave_o)));
    // R4: clear action
    p_clear_r4: assert property (@(posedge clk) disable iff (rst)
        ($past(fire) && $past(mode) == 2'b10) |-> !wave_o);
    // R4: set action
    p_set_r4: assert property (@(posedge clk) disable iff (rst)
        ($past(fire) && $past(mode) == 2'b11) |-> wave_o);
    // R4: without an action the level holds
    p_hold_r4: assert property (@(posedge clk) disable iff (rst)
        ($past(!fire || mode == 2'b00) && !$past(rst)) |-> $stable(wave_o));

endmodule

// File: rtl/ocf_channel.sv
module ocf_channel #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] cnt_val,
    input  logic          cnt_en,
    input  logic [CW-1:0] cmp_val,
    input  logic [1:0]    out_mode,
    input  logic          pwm_mode,
    input  logic          ctc_mode,
    input  logic          force_stb,
    output logic          wave_o,
    output logic          match_irq,
    output logic          clr_req
);
    typedef struct packed {
        logic irq;
        logic clr;
    } evt_st_t;

    evt_st_t ev_d, ev_q;
    logic    hit;
    logic    force_ok;
    logic    fire;

    occ_cmp #(.CW(CW)) u_cmp (
        .cnt_val (cnt_val),
        .cmp_val (cmp_val),
        .cnt_en  (cnt_en),
        .hit     (hit)
    );

    // one action per edge, however many sources ask for it
    always_comb begin
        force_ok = force_stb & ~pwm_mode;
        fire     = (hit & ~pwm_mode) | force_ok;
        ev_d.irq = hit;
        ev_d.clr = hit & ctc_mode & ~pwm_mode;
    end

    always_ff @(posedge clk) begin
        if (rst) ev_q <= '0;
        else     ev_q <= ev_d;
    end

    occ_wave u_wave (
        .clk    (clk),
        .rst    (rst),
        .fire   (fire),
        .mode   (out_mode),
        .wave_o (wave_o)
    );

    assign match_irq = ev_q.irq;
    assign clr_req   = ev_q.clr;

    // R2: a pulse only follows an enabled equal compare
    p_irq_src_r2: assert property (@(posedge clk) disable iff (rst)
        match_irq |-> $past(cnt_en && cnt_val == cmp_val));
    // R3: disabled counter gives no event
    p_no_en_r3: assert property (@(posedge clk) disable iff (rst)
        ($past(!cnt_en) && !$past(rst)) |-> (!match_irq && !clr_req));
    // R5: clear request needs clear-on-compare outside PWM, with the match pulse
    p_clr_ctc_r5: assert property (@(posedge clk) disable iff (rst)
        clr_req |-> ($past(ctc_mode && !pwm_mode) && match_irq));
    // R7: force alone raises no interrupt
    p_force_no_irq_r7: assert property (@(posedge clk) disable iff (rst)
        $past(force_stb && !(cnt_en && cnt_val == cmp_val)) |-> !match_irq);
    // R8: force alone raises no clear request
    p_force_no_clr_r8: assert property (@(posedge clk) disable iff (rst)
        $past(force_stb && !(cnt_en && cnt_val == cmp_val)) |-> !clr_req);
    // R9 / R11: PWM mode leaves the pin alone
    p_pwm_hold_r9: assert property (@(posedge clk) disable iff (rst)
        ($past(pwm_mode) && !$past(rst)) |-> $stable(wave_o));

endmodule

// File: tb/sim_ocf_channel.sv
module sim_ocf_channel;
    localparam int CW = 16;

    typedef struct {
        logic  wave;
        logic  irq;
        logic  clr;
        string tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [CW-1:0] cnt_val = '0;
    logic          cnt_en = 1'b0;
    logic [CW-1:0] cmp_val = '0;
    logic [1:0]    out_mode = 2'b00;
    logic          pwm_mode = 1'b0;
    logic          ctc_mode = 1'b0;
    logic          force_stb = 1'b0;
    logic          wave_o, match_irq, clr_req;

    int   n_chk = 0;
    int   n_fail = 0;
    logic m_wave = 1'b0;
    exp_t sb[$];
    bit   done = 1'b0;

    always #4 clk = ~clk;

    ocf_channel #(.CW(CW)) u0 (
        .clk(clk), .rst(rst), .cnt_val(cnt_val), .cnt_en(cnt_en),
        .cmp_val(cmp_val), .out_mode(out_mode), .pwm_mode(pwm_mode),
        .ctc_mode(ctc_mode), .force_stb(force_stb),
        .wave_o(wave_o), .match_irq(match_irq), .clr_req(clr_req)
    );

    task automatic check(input string tag, input logic w, input logic i, input logic c);
        n_chk++;
        if (wave_o !== w || match_irq !== i || clr_req !== c) begin
            n_fail++;
            $display("FAIL %s: wave/irq/clr actual %b%b%b expected %b%b%b",
                     tag, wave_o, match_irq, clr_req, w, i, c);
        end
    endtask

    // driver: apply one cycle of stimulus, queue the expected outputs
    task automatic step(input logic [CW-1:0] c, input logic [CW-1:0] m, input logic en,
                        input logic [1:0] mode, input logic pwm, input logic ctc,
                        input logic frc, input string tag);
        exp_t e;
        logic hit;
        @(negedge clk);
        cnt_val = c; cmp_val = m; cnt_en = en; out_mode = mode;
        pwm_mode = pwm; ctc_mode = ctc; force_stb = frc;
        hit = en && (c == m);
        if ((hit && !pwm) || (frc && !pwm)) begin
            case (mode)
                2'b01:   m_wave = ~m_wave;
                2'b10:   m_wave = 1'b0;
                2'b11:   m_wave = 1'b1;
                default: m_wave = m_wave;
            endcase
        end
        e.wave = m_wave;
        e.irq  = hit;
        e.clr  = hit && ctc && !pwm;
        e.tag  = tag;
        @(posedge clk);
        #1;
        sb.push_back(e);
    endtask

    // monitor: compare queued expectations away from the active edge
    always @(negedge clk) begin
        while (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            check(e.tag, e.wave, e.irq, e.clr);
        end
    end

    initial begin
        #1_000_000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        check("R1 in reset", 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #2;
        check("R1 after reset", 1'b0, 1'b0, 1'b0);

        step(16'd5, 16'd5, 1, 2'b01, 0, 0, 0, "R2 R4 toggle match");
        step(16'd6, 16'd5, 1, 2'b01, 0, 0, 0, "R2 pulse ends");
        step(16'd5, 16'd5, 0, 2'b01, 0, 1, 0, "R3 disabled equal");
        step(16'h00FF, 16'h00FF, 1, 2'b10, 0, 0, 0, "R4 clear");
        step(16'h1234, 16'h1234, 1, 2'b11, 0, 0, 0, "R4 set");
        step(16'hFFFF, 16'hFFFF, 1, 2'b00, 0, 0, 0, "R4 hold");
        step(16'hFFFE, 16'hFFFF, 1, 2'b10, 0, 0, 0, "R4 no match no action");
        step(16'd9, 16'd9, 1, 2'b01, 0, 1, 0, "R5 ctc clear request");
        step(16'd9, 16'd9, 1, 2'b01, 1, 1, 0, "R5 R11 pwm match");
        step(16'd3, 16'd9, 1, 2'b01, 0, 1, 1, "R6 R7 R8 force toggle");
        step(16'd4, 16'd9, 0, 2'b10, 0, 1, 1, "R6 R7 R8 force clear");
        step(16'd4, 16'd9, 1, 2'b11, 0, 0, 1, "R6 force set");
        step(16'd4, 16'd9, 1, 2'b00, 0, 1, 1, "R6 force hold mode");
        step(16'd4, 16'd9, 1, 2'b10, 1, 1, 1, "R9 force in pwm");
        step(16'd4, 16'd9, 1, 2'b01, 1, 0, 1, "R9 force toggle in pwm");
        step(16'd7, 16'd7, 1, 2'b01, 0, 1, 1, "R10 force with match");
        step(16'd7, 16'd7, 1, 2'b01, 0, 0, 1, "R10 repeat once");
        step(16'd8, 16'd7, 1, 2'b01, 0, 0, 0, "R7 idle");
        step(16'd8, 16'd8, 1, 2'b00, 1, 1, 0, "R11 pwm hold");
        step(16'd0, 16'd1, 0, 2'b00, 0, 0, 0, "R3 idle");

        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule